// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product. The partial products are summed one row per multiplier bit in a carry-save array, so no row waits for a carry to ripple. Pipeline registers split the 32 rows into groups of four. A last stage merges the sum and carry vectors with a single carry-propagate adder and joins the result to the low product bits that the array has already finished.

The pipeline never stalls. A new operand pair may be presented on every clock, qualified by `in_valid`. Each product leaves on `out_product` with `out_valid` high a fixed number of clocks later, and products leave in the order their operands arrived. A clock with `in_valid` low makes a bubble that travels through the pipeline like any other slot. Reset clears only the valid flags.

Top module: `pcsa_mul`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned 64-bit product of the `in_a` and `in_b` values that were accepted with it. `out_product[63:32]` is the high half and `out_product[31:0]` is the low half.
- R2: The latency is exactly nine clocks. `out_valid` is high in the ninth cycle after a cycle in which `in_valid` was high at a rising edge, and low otherwise.
- R3: A new pair is accepted on every clock. A burst of N back-to-back valid inputs gives N back-to-back valid outputs in arrival order.
- R4: While `rst_n` is low, `out_valid` is low, and every operation that was in flight when reset was asserted is discarded. Operands presented before the reset never appear afterwards.
- R5: Operands presented while `in_valid` is low never make `out_valid` go high, whatever their value.
- R6: Boundary operands give exact results with no carry lost out of the top half. For example, 0xFFFFFFFF × 0xFFFFFFFF = 0xFFFFFFFE00000001, and a zero operand gives zero.
- R7: Each of the eight array stages retires four multiplier bits: stage k handles bits 4k..4k+3 of `in_b`. A single set bit of `in_b` at any position gives `in_a` shifted left by that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the valid flags |
| in_valid | input | 1 | High when `in_a`/`in_b` carry an operand pair |
| in_a | input | 32 | Multiplicand, unsigned |
| in_b | input | 32 | Multiplier, unsigned |
| out_valid | output | 1 | High when `out_product` holds a result |
| out_product | output | 64 | Unsigned product |

## Verification
Every product is due exactly nine clocks after the edge that took its operands. The driver records the cycle number with each expected product in a queue. The monitor samples on falling edges and requires that each result appears exactly nine cycles after its entry, so a late or missing result is reported as well as a wrong value. A valid output with no matching entry is reported as a leaked bubble. After a reset in mid-flight the queue is emptied, so any result from before the reset shows up as unexpected.

// File: rtl/pcsa_mul_pkg.sv
package pcsa_mul_pkg;

  localparam int unsigned MAX_W = 64;
  localparam int unsigned ACC_W = 2 * MAX_W;

  // Full-adder sum across a whole vector of bit positions.
  function automatic logic [MAX_W-1:0] csa_sum(input logic [MAX_W-1:0] x,
                                               input logic [MAX_W-1:0] y,
                                               input logic [MAX_W-1:0] z);
    return x ^ y ^ z;
  endfunction

  // Full-adder carry (majority) across a vector; weight is one bit higher.
  function automatic logic [MAX_W-1:0] csa_maj(input logic [MAX_W-1:0] x,
                                               input logic [MAX_W-1:0] y,
                                               input logic [MAX_W-1:0] z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Numeric value represented by a pipeline slot: finished low bits, plus the
  // pending sum/carry pair and the rows still to be added, both scaled.
  function automatic logic [ACC_W-1:0] rem_value(input logic [MAX_W-1:0] lo,
                                                 input logic [MAX_W-1:0] s,
                                                 input logic [MAX_W-1:0] c,
                                                 input logic [MAX_W-1:0] a,
                                                 input logic [MAX_W-1:0] b,
                                                 input int unsigned      sh);
    logic [ACC_W-1:0] pend;
    pend = ACC_W'(s) + ACC_W'(c) + ACC_W'(a) * ACC_W'(b);
    return ACC_W'(lo) + (pend << sh);
  endfunction

endpackage

// File: rtl/pcsa_row_stage.sv
module pcsa_row_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ROWS  = 4,
  parameter int unsigned BASE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic [WIDTH-1:0] lo_i,
  output logic             vld_q,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] b_q,
  output logic [WIDTH-1:0] s_q,
  output logic [WIDTH-1:0] c_q,
  output logic [WIDTH-1:0] lo_q
);
  import pcsa_mul_pkg::*;

  // b_i bit r is multiplier bit BASE+r; lower bits were consumed upstream.
  logic [WIDTH-1:0] s_chain [ROWS+1];
  logic [WIDTH-1:0] c_chain [ROWS+1];
  logic [ROWS-1:0]  row_lo;
  logic [WIDTH-1:0] lo_nxt;
  logic [WIDTH-1:0] b_nxt;

  assign s_chain[0] = s_i;
  assign c_chain[0] = c_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [WIDTH-1:0] pp;
    logic [WIDTH-1:0] rsum;
    logic [WIDTH-1:0] rcar;
    assign pp   = a_i & {WIDTH{b_i[r]}};
    assign rsum = WIDTH'(csa_sum(MAX_W'(s_chain[r]), MAX_W'(c_chain[r]), MAX_W'(pp)));
    assign rcar = WIDTH'(csa_maj(MAX_W'(s_chain[r]), MAX_W'(c_chain[r]), MAX_W'(pp)));
    // Bit 0 of the sum is final; the rest moves down one weight.
    assign s_chain[r+1] = {1'b0, rsum[WIDTH-1:1]};
    assign c_chain[r+1] = rcar;
    assign row_lo[r]    = rsum[0];
  end

  always_comb begin
    lo_nxt               = lo_i;
    lo_nxt[BASE +: ROWS] = row_lo;
  end

  assign b_nxt = b_i >> ROWS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    a_q  <= a_i;
    b_q  <= b_nxt;
    s_q  <= s_chain[ROWS];
    c_q  <= c_chain[ROWS];
    lo_q <= lo_nxt;
  end

  // R2: valid flag advances by one stage per clock
  a_r2_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (vld_q == $past(vld_i)));

  // R7: four rows folded in without changing the represented value
  a_r7_stage_value: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (rem_value(MAX_W'(lo_q), MAX_W'(s_q), MAX_W'(c_q), MAX_W'(a_q),
                         MAX_W'(b_q), BASE + ROWS)
               == $past(rem_value(MAX_W'(lo_i), MAX_W'(s_i), MAX_W'(c_i), MAX_W'(a_i),
                                  MAX_W'(b_i), BASE))));

endmodule

// File: rtl/pcsa_merge.sv
module pcsa_merge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [WIDTH-1:0]   s_i,
  input  logic [WIDTH-1:0]   c_i,
  input  logic [WIDTH-1:0]   lo_i,
  output logic               vld_q,
  output logic [2*WIDTH-1:0] prod_q
);
  import pcsa_mul_pkg::*;

  logic [WIDTH:0] hi_full;
  logic           carry_out;

  assign hi_full   = {1'b0, s_i} + {1'b0, c_i};
  assign carry_out = hi_full[WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    prod_q <= {hi_full[WIDTH-1:0], lo_i};
  end

  // R6: the merged high half never carries past the top bit
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> !carry_out);

  // R7: all multiplier rows consumed before the merge
  a_r7_rows_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (b_i == '0));

  // R1: the registered product equals the value held by the last array slot
  a_r1_merge_value: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (ACC_W'(prod_q)
               == $past(rem_value(MAX_W'(lo_i), MAX_W'(s_i), MAX_W'(c_i),
                                  MAX_W'(a_i), MAX_W'(b_i), WIDTH))));

  // R2: valid flag advances into the output register
  a_r2_merge_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (vld_q == $past(vld_i)));

endmodule

// File: rtl/pcsa_mul.sv
module pcsa_mul #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ROWS  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   in_a,
  input  logic [WIDTH-1:0]   in_b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] out_product
);
  localparam int unsigned NSTG = WIDTH / ROWS;

  logic             vld_c [NSTG+1];
  logic [WIDTH-1:0] a_c   [NSTG+1];
  logic [WIDTH-1:0] b_c   [NSTG+1];
  logic [WIDTH-1:0] s_c   [NSTG+1];
  logic [WIDTH-1:0] c_c   [NSTG+1];
  logic [WIDTH-1:0] lo_c  [NSTG+1];

  assign vld_c[0] = in_valid;
  assign a_c[0]   = in_a;
  assign b_c[0]   = in_b;
  assign s_c[0]   = '0;
  assign c_c[0]   = '0;
  assign lo_c[0]  = '0;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    pcsa_row_stage #(
      .WIDTH (WIDTH),
      .ROWS  (ROWS),
      .BASE  (g * ROWS)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (vld_c[g]),
      .a_i   (a_c[g]),
      .b_i   (b_c[g]),
      .s_i   (s_c[g]),
      .c_i   (c_c[g]),
      .lo_i  (lo_c[g]),
      .vld_q (vld_c[g+1]),
      .a_q   (a_c[g+1]),
      .b_q   (b_c[g+1]),
      .s_q   (s_c[g+1]),
      .c_q   (c_c[g+1]),
      .lo_q  (lo_c[g+1])
    );
  end

  pcsa_merge #(
    .WIDTH (WIDTH)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (vld_c[NSTG]),
    .a_i    (a_c[NSTG]),
    .b_i    (b_c[NSTG]),
    .s_i    (s_c[NSTG]),
    .c_i    (c_c[NSTG]),
    .lo_i   (lo_c[NSTG]),
    .vld_q  (out_valid),
    .prod_q (out_product)
  );

  // R4: no valid output while reset is held
  a_r4_reset_clears: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

// File: tb/pcsa_mul_bench.sv
module pcsa_mul_bench;

  localparam int LAT = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_product;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] rng = 32'h1234_5678;

  typedef struct {
    logic [63:0] exp;
    int          t;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;  // 200 MHz

  always @(posedge clk) cyc <= cyc + 1;

  pcsa_mul u_pcsa_mul (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    it.exp = {32'd0, a} * {32'd0, b};
    it.t = cyc;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // R5: idle slots carry junk operands
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rng = next_rand(rng);
      in_valid = 1'b0;
      in_a = rng;
      in_b = ~rng;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R5 unexpected out_valid: got product %h, expected no output", out_product);
        end else begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (cyc - it.t != LAT) begin
            failures++;
            $display("FAIL R2 R3 latency: got %0d cycles, expected %0d", cyc - it.t, LAT);
          end
          checks++;
          if (out_product !== it.exp) begin
            failures++;
            $display("FAIL %s product: got %h, expected %h", it.tag, out_product, it.exp);
          end
        end
      end else if (sb.size() != 0 && sb[0].t + LAT <= cyc) begin
        checks++; failures++;
        $display("FAIL R2 missing result: got out_valid=0, expected product %h", sb[0].exp);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    // R4: reset state
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R4 reset out_valid: got %b, expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 / R2: single operation
    send(32'd3, 32'd5, "R1");
    idle(12);

    // R5: valid slots interleaved with junk bubbles
    for (int i = 0; i < 10; i++) begin
      rng = next_rand(rng);
      send(rng, next_rand(rng), "R5");
      idle(1 + (i % 3));
    end
    idle(12);

    // R3: back-to-back burst
    for (int i = 0; i < 40; i++) begin
      rng = next_rand(rng);
      send(rng, next_rand(~rng), "R3");
    end
    idle(12);

    // R6: boundary operands
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    send(32'h0000_0000, 32'hDEAD_BEEF, "R6");
    send(32'hCAFE_F00D, 32'h0000_0000, "R6");
    send(32'h0000_0001, 32'h8765_4321, "R6");
    send(32'hFFFF_FFFF, 32'h0000_0001, "R6");
    send(32'h8000_0000, 32'h8000_0000, "R6");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFE, "R6");
    idle(12);

    // R7: walking multiplier bit through every row of every stage
    for (int k = 0; k < 32; k++) begin
      send(32'hF0E1_D2C3, 32'h1 << k, "R7");
    end
    send(32'hFFFF_FFFF, 32'hF000_000F, "R7");
    idle(12);

    // R4: reset in flight discards pending operations
    for (int i = 0; i < 5; i++) begin
      rng = next_rand(rng);
      send(rng, rng ^ 32'h5A5A_5A5A, "R4");
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    sb.delete();
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL R4 out_valid during reset: got %b, expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL R4 stale result after reset: got %b, expected 0", out_valid);
      end
    end

    // R1: operation after reset
    send(32'h0001_0000, 32'h0001_0000, "R1");
    send(32'd123456789, 32'd987654321, "R1");
    idle(14);

    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R2 undelivered results: got %0d pending, expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule